// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a single-cycle processor that runs a subset of a 32-bit RISC instruction set with fixed 32-bit, word-aligned instructions. In every cycle it looks at the instruction currently being fetched and picks one of four next-address sources. The sources are SEQUENTIAL (PC + 4), BRANCH (a PC-relative target), JUMP (a pseudo-direct target taken from the instruction) and REGISTER (the value read from the source register). The choice is coded as an enumerated source selector, and the PC register loads the chosen address on the next clock edge.

The surrounding datapath supplies three inputs: the instruction word, the value read from the register named in the instruction's rs field, and a branch-condition flag from an external comparator. The block returns the current PC and the next PC. When the instruction is jump-and-link, it also raises a one-cycle write request that carries the return address and destination register 31, so that a later register jump through register 31 returns to the caller.

The selector has four values, and any of them can follow any other. SEQUENTIAL is used for any opcode that is not decoded, for R-format words whose funct is not 8, and for a branch whose condition flag is low. BRANCH is used for opcode 4 or 5 with the flag high. JUMP is used for opcode 2 or 3. REGISTER is used for opcode 0 with funct 8. Reset is a synchronous hold state outside the selector: while reset is high, the PC loads the reset vector on every edge.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` loads the parameter RESET_VEC (default 0x00000000). It stays at that value for every edge on which `rst` remains high.
- R2: Some instructions leave the sequence unchanged: any opcode other than 0, 2, 3, 4 and 5 (opcode is bits 31:26), and opcode 0 with a funct (bits 5:0) other than 8. For these, the next PC is PC + 4.
- R3: Opcode 4 (equal) or opcode 5 (not equal) with `cond_met` high selects the branch target. The target is PC + 4 plus bits 15:0, sign-extended to 32 bits and shifted left by two. With `cond_met` low the next PC is PC + 4. Negative offsets, including the most negative offset 0x8000, wrap modulo 2^32.
- R4: Opcode 0 with funct 8 is a register jump. The next PC is `rs_value` with bits 1:0 forced to zero.
- R5: Opcode 2 is a jump. The next PC is bits 31:28 of PC + 4, followed by bits 25:0 of the instruction, followed by two zero bits.
- R6: Opcode 3 takes the same target as R5. In the same cycle it drives `link_we` high, `link_addr` to 31 and `link_data` to PC + 4. `link_we` is low for every other instruction and whenever `rst` is high.
- R7: `pc_next` always equals the address that `pc` takes at the following edge when `rst` is low. Bits 1:0 of `pc` are always zero.
- R8: `cond_met` has no effect unless the instruction is opcode 4 or 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word at the current PC |
| rs_value | input | 32 | Contents of the register named by bits 25:21 |
| cond_met | input | 1 | Branch condition resolved by an external comparator |
| pc | output | 32 | Current program counter |
| pc_next | output | 32 | Address to be loaded at the next edge |
| link_we | output | 1 | Return-address write request (jump-and-link) |
| link_addr | output | 5 | Destination register of the link write (31) |
| link_data | output | 32 | Return address, PC + 4 |

## Verification
The hardest cases to reach from the ports depend on the PC's own history. The upper four bits of PC + 4 feed the pseudo-direct jump, and large negative branch offsets must wrap correctly. Neither can be reached from a PC near zero. The vector table is therefore one connected program. An unaligned register jump moves the PC into a high region, a jump then proves that the region bits are kept, and a branch with the most negative offset later carries the PC back across a 256 MB boundary. On that new PC, a jump-and-link whose target field is all ones gives a second, different set of region bits. Fetches with the condition flag high on non-branch words, together with an undecoded R-format funct, show that those inputs leave the PC on its sequential path.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int ADDR_W   = 32;
    localparam int OPC_W    = 6;
    localparam int FUNCT_W  = 6;
    localparam int IMM_W    = 16;
    localparam int JIDX_W   = 26;
    localparam int REGIDX_W = 5;
    localparam int REGION_W = ADDR_W - JIDX_W - 2;

    localparam logic [OPC_W-1:0]   OP_RTYPE = 6'd0;
    localparam logic [OPC_W-1:0]   OP_JUMP  = 6'd2;
    localparam logic [OPC_W-1:0]   OP_JLINK = 6'd3;
    localparam logic [OPC_W-1:0]   OP_BREQ  = 6'd4;
    localparam logic [OPC_W-1:0]   OP_BRNE  = 6'd5;
    localparam logic [FUNCT_W-1:0] FN_REGJ  = 6'd8;

    localparam logic [REGIDX_W-1:0] RET_REG = 5'd31;
    localparam logic [ADDR_W-1:0]   STEP    = 32'd4;

    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2,
        SRC_REG    = 2'd3
    } next_src_e;

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
    import pcu_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode,
    input  logic [FUNCT_W-1:0] funct,
    input  logic               cond_met,
    output next_src_e          sel,
    output logic               is_link
);

    always_comb begin
        sel     = SRC_SEQ;
        is_link = 1'b0;
        unique case (opcode)
            OP_RTYPE: sel = (funct == FN_REGJ) ? SRC_REG : SRC_SEQ;
            OP_JUMP:  sel = SRC_JUMP;
            OP_JLINK: begin
                sel     = SRC_JUMP;
                is_link = 1'b1;
            end
            OP_BREQ, OP_BRNE: sel = cond_met ? SRC_BRANCH : SRC_SEQ;
            default:  sel = SRC_SEQ;
        endcase
    end

    // R6: a link request only ever comes with a pseudo-direct jump
    always_comb begin
        if (is_link) begin
            assert_link_with_jump_R6: assert (sel == SRC_JUMP);
        end
    end

endmodule

// File: rtl/pcu_targets.sv
module pcu_targets
    import pcu_pkg::*;
(
    input  logic [ADDR_W-1:0]   pc,
    input  logic [JIDX_W-1:0]   index_field,
    input  logic [ADDR_W-1:2]   rs_word,
    output logic [ADDR_W-1:0]   seq_addr,
    output logic [ADDR_W-1:0]   branch_addr,
    output logic [ADDR_W-1:0]   jump_addr,
    output logic [ADDR_W-1:0]   reg_addr
);

    localparam int SEXT_W = ADDR_W - IMM_W - 2;

    logic [IMM_W-1:0]  offset;
    logic [ADDR_W-1:0] offset_bytes;

    assign offset       = index_field[IMM_W-1:0];
    assign offset_bytes = {{SEXT_W{offset[IMM_W-1]}}, offset, 2'b00};

    always_comb begin
        seq_addr    = pc + STEP;
        branch_addr = seq_addr + offset_bytes;
        jump_addr   = {seq_addr[ADDR_W-1 -: REGION_W], index_field, 2'b00};
        reg_addr    = {rs_word, 2'b00};
    end

endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg
    import pcu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VEC;
        end else begin
            q <= d;
        end
    end

    // R1: an edge with reset high leaves the reset vector in the register
    assert_reset_load_R1: assert property (@(posedge clk)
        $past(rst) |-> (q == RESET_VEC));

    // R7: the register never holds an unaligned address
    assert_pc_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        q[1:0] == 2'b00);

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pcu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   instr,
    input  logic [ADDR_W-1:0]   rs_value,
    input  logic                cond_met,
    output logic [ADDR_W-1:0]   pc,
    output logic [ADDR_W-1:0]   pc_next,
    output logic                link_we,
    output logic [REGIDX_W-1:0] link_addr,
    output logic [ADDR_W-1:0]   link_data
);

    next_src_e         sel;
    logic              is_link;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] branch_addr;
    logic [ADDR_W-1:0] jump_addr;
    logic [ADDR_W-1:0] reg_addr;

    pcu_decode u_decode (
        .opcode   (instr[ADDR_W-1 -: OPC_W]),
        .funct    (instr[FUNCT_W-1:0]),
        .cond_met (cond_met),
        .sel      (sel),
        .is_link  (is_link)
    );

    pcu_targets u_targets (
        .pc          (pc),
        .index_field (instr[JIDX_W-1:0]),
        .rs_word     (rs_value[ADDR_W-1:2]),
        .seq_addr    (seq_addr),
        .branch_addr (branch_addr),
        .jump_addr   (jump_addr),
        .reg_addr    (reg_addr)
    );

    always_comb begin
        unique case (sel)
            SRC_SEQ:    pc_next = seq_addr;
            SRC_BRANCH: pc_next = branch_addr;
            SRC_JUMP:   pc_next = jump_addr;
            SRC_REG:    pc_next = reg_addr;
            default:    pc_next = seq_addr;
        endcase
    end

    pcu_pc_reg #(.RESET_VEC(RESET_VEC)) u_pc_reg (
        .clk (clk),
        .rst (rst),
        .d   (pc_next),
        .q   (pc)
    );

    always_comb begin
        link_we   = is_link & ~rst;
        link_addr = RET_REG;
        link_data = seq_addr;
    end

    // R2: the sequential source advances the PC by one word
    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (sel == SRC_SEQ) |=> (pc == $past(pc) + STEP));

    // R4: a register jump lands on the aligned register value
    assert_regjump_target_R4: assert property (@(posedge clk) disable iff (rst)
        (sel == SRC_REG) |=> (pc == {$past(rs_value[ADDR_W-1:2]), 2'b00}));

    // R5: a pseudo-direct jump keeps the region of the following word
    assert_jump_region_R5: assert property (@(posedge clk) disable iff (rst)
        (sel == SRC_JUMP) |=> (pc[ADDR_W-1 -: REGION_W] == $past(seq_addr[ADDR_W-1 -: REGION_W])));

    // R6: after a link request the PC sits in the return address's region
    assert_link_region_R6: assert property (@(posedge clk) disable iff (rst)
        link_we |=> (pc[ADDR_W-1 -: REGION_W] == $past(link_data[ADDR_W-1 -: REGION_W])));

    // R7: the announced next address is the one that gets loaded
    assert_next_loaded_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pc == $past(pc_next)));

endmodule

// File: tb/pc_next_unit_bench.sv
module pc_next_unit_bench;

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] rs;
        logic        cond;
        logic [31:0] exp_pc;
        logic [31:0] exp_next;
        logic        exp_link;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{32'h02324020, 32'h0000_0000, 1'b1, 32'h0000_0000, 32'h0000_0004, 1'b0},
        '{32'h10000003, 32'h0000_0000, 1'b1, 32'h0000_0004, 32'h0000_0014, 1'b0},
        '{32'h14000005, 32'h0000_0000, 1'b0, 32'h0000_0014, 32'h0000_0018, 1'b0},
        '{32'h1400FFFE, 32'h0000_0000, 1'b1, 32'h0000_0018, 32'h0000_0014, 1'b0},
        '{32'h08000100, 32'h0000_0000, 1'b1, 32'h0000_0014, 32'h0000_0400, 1'b0},
        '{32'h0C000200, 32'h0000_0000, 1'b0, 32'h0000_0400, 32'h0000_0800, 1'b1},
        '{32'h03E00008, 32'h0000_0404, 1'b0, 32'h0000_0800, 32'h0000_0404, 1'b0},
        '{32'h01A00008, 32'h1234_5677, 1'b1, 32'h0000_0404, 32'h1234_5674, 1'b0},
        '{32'h08000010, 32'h0000_0000, 1'b0, 32'h1234_5674, 32'h1000_0040, 1'b0},
        '{32'h8E110004, 32'h0000_0000, 1'b1, 32'h1000_0040, 32'h1000_0044, 1'b0},
        '{32'h03E00009, 32'h0000_0080, 1'b1, 32'h1000_0044, 32'h1000_0048, 1'b0},
        '{32'h10000010, 32'h0000_0000, 1'b0, 32'h1000_0048, 32'h1000_004C, 1'b0},
        '{32'h10008000, 32'h0000_0000, 1'b1, 32'h1000_004C, 32'h0FFE_0050, 1'b0},
        '{32'h0FFFFFFF, 32'h0000_0000, 1'b1, 32'h0FFE_0050, 32'h0FFF_FFFC, 1'b1}
    };

    localparam logic [31:0] ALT_VEC = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'h0C000200;
    logic [31:0] rs_value = '0;
    logic        cond_met = 1'b0;
    logic [31:0] pc, pc_next, link_data;
    logic [31:0] pc_alt, pc_next_alt, link_data_alt;
    logic [4:0]  link_addr, link_addr_alt;
    logic        link_we, link_we_alt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pc_next_unit u_pc_next_unit (
        .clk(clk), .rst(rst), .instr(instr), .rs_value(rs_value), .cond_met(cond_met),
        .pc(pc), .pc_next(pc_next), .link_we(link_we), .link_addr(link_addr),
        .link_data(link_data)
    );

    pc_next_unit #(.RESET_VEC(ALT_VEC)) u_pc_next_unit_alt (
        .clk(clk), .rst(rst), .instr(instr), .rs_value(rs_value), .cond_met(cond_met),
        .pc(pc_alt), .pc_next(pc_next_alt), .link_we(link_we_alt), .link_addr(link_addr_alt),
        .link_data(link_data_alt)
    );

    function automatic string tag_of(input logic [31:0] w, input logic c);
        case (w[31:26])
            6'd0:       return (w[5:0] == 6'd8) ? "R4" : "R2";
            6'd2:       return "R5";
            6'd3:       return "R6";
            6'd4, 6'd5: return "R3";
            default:    return c ? "R8" : "R2";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: hold reset over two edges with a jump-and-link word present
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "pc in reset", pc, 32'h0);
        check("R1", "alt pc in reset", pc_alt, ALT_VEC);
        check("R6", "link_we in reset", {31'b0, link_we}, 32'h0);

        // vector program, one instruction per cycle
        for (int i = 0; i < NVEC; i++) begin
            rst      = 1'b0;
            instr    = VECS[i].instr;
            rs_value = VECS[i].rs;
            cond_met = VECS[i].cond;
            #1;
            check(tag_of(VECS[i].instr, VECS[i].cond), "pc", pc, VECS[i].exp_pc);
            check("R7", "pc_next", pc_next, VECS[i].exp_next);
            check("R6", "link_we", {31'b0, link_we}, {31'b0, VECS[i].exp_link});
            if (VECS[i].exp_link) begin
                check("R6", "link_addr", {27'b0, link_addr}, 32'd31);
                check("R6", "link_data", link_data, VECS[i].exp_pc + 32'd4);
            end
            @(negedge clk);
        end
        // R7: the last vector's target was loaded
        check("R7", "final pc", pc, VECS[NVEC-1].exp_next);

        // R1: reset in mid-run, with a register jump on the inputs
        rst      = 1'b1;
        instr    = 32'h03E00008;
        rs_value = 32'hDEAD_BEE0;
        @(negedge clk);
        check("R1", "pc after mid-run reset", pc, 32'h0);
        check("R1", "alt pc after mid-run reset", pc_alt, ALT_VEC);
        @(negedge clk);
        check("R1", "pc held in reset", pc, 32'h0);

        // R2: first step out of the non-default reset vector
        instr    = 32'h02324020;
        cond_met = 1'b1;
        rst      = 1'b0;
        #1;
        check("R2", "alt pc_next after reset", pc_next_alt, ALT_VEC + 32'd4);
        @(negedge clk);
        check("R2", "alt pc stepped", pc_alt, ALT_VEC + 32'd4);
        check("R8", "pc stepped with cond high", pc, 32'h4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule